// File: doc/BRIEF.md
# SPI Flash Block-Erase Sequencer

This block lives on the host side of a serial NOR flash link. It erases one 32 KB or 64 KB block with no software involved. A single start pulse captures the erase size and a 24-bit byte address. The block then runs three kinds of SPI mode 0 transactions back to back.

First comes a one-byte write-enable frame. Next is the erase frame: the size-dependent opcode and three address bytes, all under one chip-select assertion. Raising chip select at the end of that frame is what commits the erase inside the flash. After that, the block sends status-read frames repeatedly and watches the last bit of the returned byte. When that bit reads clear, the block raises a one-cycle completion pulse. If the bit stays set through a programmable number of reads, it raises a one-cycle timeout pulse instead.

The serial clock is derived from the system clock. Each SCK half period lasts `CLK_DIV` system clocks. Chip select stays high for at least `CS_GAP` system clocks between any two frames.

Top module: `spi_erase_seq`

## Requirements
- R1: While reset is asserted and after its release, csN is high, sck is low, and busy, done and timeout are low.
- R2: Each sequence begins with a frame of exactly 8 SCK cycles carrying byte 0x06. Chip select is low for that frame and returns high after it.
- R3: The second frame is 32 SCK cycles within one chip-select low period. It carries opcode 0x52 when sizeSel is 0, or 0xD8 when sizeSel is 1, followed by the 24 address bits. Every byte goes out MSB first.
- R4: sck is low whenever csN is high. mosi changes only while sck is low, and miso is sampled at each sck rising edge.
- R5: After the erase frame, the block sends status frames of 16 SCK cycles: byte 0x05 followed by 8 read clocks. Bit 0 of the returned byte, which is the last bit received, is the busy flag. A new status frame follows while that bit is 1. The other status bits have no effect.
- R6: Between the end of one frame and the start of the next, csN stays high for at least CS_GAP system clocks.
- R7: When a status read returns bit 0 clear, done pulses for one cycle, busy goes low in that same cycle, and no further frame is started.
- R8: If pollLimit consecutive status reads all return bit 0 set, polling stops. timeout then pulses for one cycle with busy low, and done stays low. A pollLimit of 0 acts as 1.
- R9: busy rises in the cycle after start is sampled. While busy is high, a start pulse does not alter the sequence, its address or its size.
- R10: Each sck high phase and each low phase inside a frame lasts CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that launches an erase sequence |
| sizeSel | input | 1 | 0 = 32 KB block, 1 = 64 KB block |
| addr | input | 24 | Byte address inside the block to erase |
| pollLimit | input | LIMIT_W | Maximum number of busy status reads before timeout |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, idles low |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | High from start until done or timeout |
| done | output | 1 | One-cycle pulse when the erase has completed |
| timeout | output | 1 | One-cycle pulse when the poll limit was reached |

## Verification
The hardest situation to reach is a start pulse arriving mid-sequence, especially while status polling is under way. A start that simply collides with the launch edge tells nothing. The bench uses a flash model that reports busy for a chosen number of status reads, which stretches the polling phase. It then fires a second start with a different size and address well after the first launch. The captured frames must still carry only the original opcode and address. The timeout path is reached the same way: the model is told to stay busy for longer than pollLimit.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_ERASE32 = 8'h52;
  localparam logic [7:0] OP_ERASE64 = 8'hD8;
  localparam logic [7:0] OP_RDSTAT  = 8'h05;

  localparam int WORD_W = 32;

  // Strobes from the sequencer to the shifter.
  typedef struct packed {
    logic              launch;
    logic [5:0]        lenBits;
    logic [WORD_W-1:0] txWord;   // left-aligned, MSB goes out first
  } frameCmd_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WREN,
    S_ERASE,
    S_POLL
  } seqState_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_SHIFT,
    P_GAP
  } phase_t;

endpackage

// File: rtl/erase_seq_shifter.sv
module erase_seq_shifter
  import erase_seq_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  frameCmd_t cmd,
  input  logic      miso,
  output logic      sck,
  output logic      csN,
  output logic      mosi,
  output logic      lastSample,
  output logic      frameDone
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);

  phase_t            phase;
  logic [WORD_W-1:0] shiftReg;
  logic [5:0]        bitsLeft;
  logic [DIV_W-1:0]  divCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              sckReg;
  logic              csNReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= P_IDLE;
      shiftReg   <= '0;
      bitsLeft   <= '0;
      divCnt     <= '0;
      gapCnt     <= '0;
      sckReg     <= 1'b0;
      csNReg     <= 1'b1;
      lastSample <= 1'b0;
      frameDone  <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      unique case (phase)
        P_IDLE: begin
          if (cmd.launch) begin
            shiftReg <= cmd.txWord;
            bitsLeft <= cmd.lenBits;
            divCnt   <= '0;
            csNReg   <= 1'b0;
            phase    <= P_SHIFT;
          end
        end
        P_SHIFT: begin
          if (divCnt == DIV_LAST) begin
            divCnt <= '0;
            if (!sckReg) begin
              sckReg     <= 1'b1;
              lastSample <= miso;
            end else begin
              sckReg   <= 1'b0;
              shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
              bitsLeft <= bitsLeft - 6'd1;
              if (bitsLeft == 6'd1) begin
                csNReg <= 1'b1;
                gapCnt <= '0;
                phase  <= P_GAP;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        P_GAP: begin
          if (gapCnt == GAP_LAST) begin
            frameDone <= 1'b1;
            phase     <= P_IDLE;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  assign sck  = sckReg;
  assign csN  = csNReg;
  assign mosi = shiftReg[WORD_W-1];

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               sizeSel,
  input  logic [23:0]        addr,
  input  logic [LIMIT_W-1:0] pollLimit,
  input  logic               frameDone,
  input  logic               statusBusy,
  output frameCmd_t          cmd,
  output logic               busy,
  output logic               done,
  output logic               timeout
);

  seqState_t          state;
  logic [23:0]        addrQ;
  logic               sizeQ;
  logic [LIMIT_W-1:0] limitQ;
  logic [LIMIT_W-1:0] pollCnt;
  logic [LIMIT_W:0]   pollNext;

  assign pollNext = {1'b0, pollCnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cmd     <= '0;
      addrQ   <= '0;
      sizeQ   <= 1'b0;
      limitQ  <= '0;
      pollCnt <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      cmd.launch <= 1'b0;
      done       <= 1'b0;
      timeout    <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            addrQ  <= addr;
            sizeQ  <= sizeSel;
            limitQ <= pollLimit;
            cmd    <= '{launch: 1'b1, lenBits: 6'd8, txWord: {OP_WREN, 24'h0}};
            state  <= S_WREN;
          end
        end
        S_WREN: begin
          if (frameDone) begin
            cmd   <= '{launch: 1'b1, lenBits: 6'd32,
                       txWord: {(sizeQ ? OP_ERASE64 : OP_ERASE32), addrQ}};
            state <= S_ERASE;
          end
        end
        S_ERASE: begin
          if (frameDone) begin
            cmd     <= '{launch: 1'b1, lenBits: 6'd16, txWord: {OP_RDSTAT, 24'h0}};
            pollCnt <= '0;
            state   <= S_POLL;
          end
        end
        S_POLL: begin
          if (frameDone) begin
            if (!statusBusy) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else if (pollNext >= {1'b0, limitQ}) begin
              timeout <= 1'b1;
              state   <= S_IDLE;
            end else begin
              pollCnt <= pollNext[LIMIT_W-1:0];
              cmd     <= '{launch: 1'b1, lenBits: 6'd16, txWord: {OP_RDSTAT, 24'h0}};
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 4,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               sizeSel,
  input  logic [23:0]        addr,
  input  logic [LIMIT_W-1:0] pollLimit,
  input  logic               miso,
  output logic               sck,
  output logic               csN,
  output logic               mosi,
  output logic               busy,
  output logic               done,
  output logic               timeout
);

  frameCmd_t cmd;
  logic      frameDone;
  logic      lastSample;

  erase_seq_ctrl #(.LIMIT_W(LIMIT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .sizeSel    (sizeSel),
    .addr       (addr),
    .pollLimit  (pollLimit),
    .frameDone  (frameDone),
    .statusBusy (lastSample),
    .cmd        (cmd),
    .busy       (busy),
    .done       (done),
    .timeout    (timeout)
  );

  erase_seq_shifter #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_shift (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .miso       (miso),
    .sck        (sck),
    .csN        (csN),
    .mosi       (mosi),
    .lastSample (lastSample),
    .frameDone  (frameDone)
  );

endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker #(
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic sck,
  input logic csN,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic timeout
);

  logic [15:0] highRun;
  logic        seenFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun   <= '0;
      seenFrame <= 1'b0;
    end else begin
      if (csN) begin
        if (highRun != 16'hFFFF) highRun <= highRun + 16'd1;
      end else begin
        highRun   <= '0;
        seenFrame <= 1'b1;
      end
    end
  end

  // R4: clock idles low outside a frame
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R4: data only moves while the clock is low
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sck) |-> $stable(mosi));

  // R6: minimum deselect time between frames
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && seenFrame) |-> (highRun >= 16'(CS_GAP)));

  // R7: completion ends the busy window
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !timeout && $past(busy)));

  // R8: timeout ends the busy window
  p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> (!busy && $past(busy)));

  // R7, R8: busy only falls with a completion or timeout pulse
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || timeout));

  // R9: a start while busy does not end or restart the sequence
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done || timeout));

endmodule

bind spi_erase_seq erase_seq_checker #(.CS_GAP(CS_GAP)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .sck     (sck),
  .csN     (csN),
  .mosi    (mosi),
  .busy    (busy),
  .done    (done),
  .timeout (timeout)
);

// File: tb/spi_erase_seq_bench.sv
`timescale 1ns/1ps
module spi_erase_seq_bench;

  localparam int DIV = 2;
  localparam int GAP = 3;
  localparam int LW  = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          sizeSel = 1'b0;
  logic [23:0]   addr = '0;
  logic [LW-1:0] pollLimit = '0;
  logic          miso = 1'b0;
  logic          sck, csN, mosi, busy, done, timeout;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_erase_seq #(.CLK_DIV(DIV), .CS_GAP(GAP), .LIMIT_W(LW)) u_spi_erase_seq (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel), .addr(addr),
    .pollLimit(pollLimit), .miso(miso), .sck(sck), .csN(csN), .mosi(mosi),
    .busy(busy), .done(done), .timeout(timeout)
  );

  // ---------------- flash model and frame log ----------------
  logic [31:0] fWord;
  logic [7:0]  fOp;
  int          fBits;
  logic [31:0] frWord [0:31];
  int          frBits [0:31];
  int          frameCount = 0;
  int          busyLeft = 0;
  realtime     lastRise = 0, riseT = 0, fallT = 0;
  int          minGap = 1000000, minHigh = 1000000, maxHigh = 0;
  int          minLow = 1000000, maxLow = 0;
  int          modeViol = 0;
  logic [7:0]  statByte;

  assign statByte = {7'b1010101, (busyLeft > 0)};

  always @(negedge csN) begin
    fWord = '0; fBits = 0; fOp = '0;
    if (frameCount > 0 && int'(($realtime - lastRise) / 8.0) < minGap)
      minGap = int'(($realtime - lastRise) / 8.0);
  end

  always @(posedge sck) if (csN === 1'b0) begin
    if (fBits > 0) begin
      if (int'(($realtime - fallT) / 8.0) < minLow) minLow = int'(($realtime - fallT) / 8.0);
      if (int'(($realtime - fallT) / 8.0) > maxLow) maxLow = int'(($realtime - fallT) / 8.0);
    end
    fWord = {fWord[30:0], mosi};
    fBits++;
    if (fBits == 8) fOp = fWord[7:0];
    riseT = $realtime;
  end

  always @(negedge sck) if (csN === 1'b0) begin
    fallT = $realtime;
    if (int'((fallT - riseT) / 8.0) < minHigh) minHigh = int'((fallT - riseT) / 8.0);
    if (int'((fallT - riseT) / 8.0) > maxHigh) maxHigh = int'((fallT - riseT) / 8.0);
    if (fBits >= 8 && fBits < 16 && fOp == 8'h05) miso <= statByte[15 - fBits];
  end

  always @(posedge csN) begin
    if (frameCount < 32) begin
      frWord[frameCount] = fWord;
      frBits[frameCount] = fBits;
    end
    frameCount++;
    lastRise = $realtime;
    if (fOp == 8'h05 && fBits == 16 && busyLeft > 0) busyLeft--;
    fOp = '0;
  end

  always @(mosi) if (csN === 1'b0 && sck === 1'b1) modeViol++;

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    frameCount = 0; minGap = 1000000; minHigh = 1000000; maxHigh = 0;
    minLow = 1000000; maxLow = 0; modeViol = 0;
  endtask

  task automatic pulseStart(input logic sz, input logic [23:0] a, input int lim);
    @(negedge clk);
    sizeSel = sz; addr = a; pollLimit = LW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEnd(output bit gotDone, output bit gotTo);
    gotDone = 0; gotTo = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done || timeout) begin
        gotDone = done; gotTo = timeout;
        chk(!busy, "R7", "busy low with end pulse", busy, 0);
        break;
      end
    end
    chk(gotDone || gotTo, "R7", "sequence ended", 0, 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(csN && !sck && !busy && !done && !timeout, "R1", "outputs in reset",
        {csN, sck, busy, done, timeout}, 5'b10000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(csN && !sck && !busy && !done && !timeout, "R1", "outputs after reset",
        {csN, sck, busy, done, timeout}, 5'b10000);
  endtask

  task automatic runErase(input logic sz, input logic [23:0] a, input int busyReads,
                          input int lim, input bit expTo, input bit poke);
    bit gotDone, gotTo;
    int nStat;
    clearLog();
    busyLeft = busyReads;
    pulseStart(sz, a, lim);
    chk(busy, "R9", "busy after start", busy, 1);
    if (poke) begin
      repeat (200) @(negedge clk);
      pulseStart(~sz, ~a, 1);
      chk(busy, "R9", "busy kept after second start", busy, 1);
    end
    waitEnd(gotDone, gotTo);
    if (expTo) begin
      chk(gotTo && !gotDone, "R8", "timeout pulse", {gotDone, gotTo}, 2'b01);
    end else begin
      chk(gotDone && !gotTo, "R7", "done pulse", {gotDone, gotTo}, 2'b10);
    end
    repeat (20) @(negedge clk);
    chk(csN && !busy && !done && !timeout, "R7", "idle after end",
        {csN, busy, done, timeout}, 4'b1000);
    nStat = expTo ? ((lim == 0) ? 1 : lim) : busyReads + 1;
    chk(frameCount == 2 + nStat, expTo ? "R8" : "R5", "frame count", frameCount, 2 + nStat);
    chk(frBits[0] == 8 && frWord[0][7:0] == 8'h06, "R2", "write-enable frame",
        frWord[0][7:0], 8'h06);
    chk(frBits[1] == 32, "R3", "erase frame length", frBits[1], 32);
    chk(frWord[1] == {(sz ? 8'hD8 : 8'h52), a}, "R3", "erase opcode and address",
        frWord[1], {(sz ? 8'hD8 : 8'h52), a});
    for (int k = 2; k < 2 + nStat && k < 32; k++)
      chk(frBits[k] == 16 && frWord[k][15:8] == 8'h05, "R5", "status frame",
          {frBits[k][7:0], frWord[k][15:8]}, {8'd16, 8'h05});
    chk(minGap >= GAP, "R6", "deselect gap", minGap, GAP);
    chk(minHigh == DIV && maxHigh == DIV, "R10", "sck high phase", maxHigh, DIV);
    chk(minLow == DIV && maxLow == DIV, "R10", "sck low phase", maxLow, DIV);
    chk(modeViol == 0, "R4", "mosi moved with sck high", modeViol, 0);
  endtask

  task automatic testErase32();  runErase(1'b0, 24'h123456, 2, 10, 0, 0); endtask
  task automatic testErase64();  runErase(1'b1, 24'hFEDCBA, 0, 5, 0, 0);  endtask
  task automatic testTimeout();  runErase(1'b0, 24'h0A0B0C, 20, 3, 1, 0); endtask
  task automatic testLimitZero(); runErase(1'b1, 24'h00FFFF, 5, 0, 1, 0); endtask
  task automatic testIgnoredStart(); runErase(1'b1, 24'h5A0000, 4, 20, 0, 1); endtask

  // ---------------- watchdog ----------------
  initial begin
    #(150000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testErase32();
    testErase64();
    testTimeout();
    testLimitZero();
    testIgnoredStart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule